// File: doc/BRIEF.md
# ATA Taskfile Load and Readback Sequencer

This block moves a whole ATA taskfile between a register image held in the host and the drive's byte-wide register window. It does this as a series of single-register accesses on a simple request/acknowledge bus. A load request writes every field whose enable bit is set, in a fixed order. The high-order (48-bit) bytes go before their low-order partners so that the drive's two-deep register FIFOs end up with the right values, and the device register goes last with its reserved bits forced by addressing mode. A read request gathers the selected fields back into a result image. It first writes the device control register with the high-order-byte select bit clear to read the low halves. In 48-bit mode it then writes that register again with the select bit set and reads the high halves.

An optional 16-bit data word travels as a single wide access at the data offset. The block keeps at most one access outstanding and waits for the acknowledge before moving to the next step. It reports `busy` while a transfer runs and pulses `done` once at the end. Command issue, status polling and interrupt handling belong elsewhere.

Top module: `ata_tf_sequencer`

## Requirements
- R1: After reset `busy`, `done` and `bus_req` are 0 and every byte of `tf_out` is 0.
- R2: A load writes, in this order: the data word (if enabled), then the enabled high-order bytes for feature, sector count, LBA low, LBA mid and LBA high at offsets 1, 2, 3, 4 and 5, then the enabled low-order bytes of the same five fields at the same offsets, and finally the device register at offset 6.
- R3: The device byte written equals (image device byte AND mask) OR `drv_sel`. The mask is 0xFF when `flagged` is 1, otherwise 0xE0 when `lba48` is 1, and 0xEF otherwise.
- R4: The data word is moved as one access with `bus_wide`=1 at offset 0, the only access that asserts `bus_wide`. On load its low byte comes from image slot 0 and its high byte from slot 1. On readback bits 7:0 go to slot 0 and bits 15:8 to slot 1.
- R5: A readback does the data word read (if enabled), then always writes the control register (`bus_ctl`=1) with 0x08. It then reads the enabled low-order feature, sector count, LBA low, LBA mid and LBA high at offsets 1 to 5 into slots 2 to 6, and the device register at offset 6 into slot 7.
- R6: A readback with `lba48`=1 then writes the control register with 0x88 and reads the enabled high-order bytes at offsets 1 to 5 into slots 8 to 12. With `lba48`=0 neither happens. Every control write carries 0x08 or 0x88.
- R7: `field_en` bit 0 enables the data word, bits 1 to 5 the low-order feature, sector count, LBA low, LBA mid and LBA high, bit 6 the device register, and bits 7 to 11 the high-order feature to LBA high. A disabled field is never accessed, and on readback its `tf_out` slot (byte k at bits 8k+7:8k) keeps its value.
- R8: At most one access is outstanding. `bus_req` stays high with address, direction, width and write data unchanged until the cycle `bus_ack` is seen.
- R9: `busy` rises in the cycle after a request is accepted and stays high until the last access is acknowledged. It falls in the same cycle that `done` is high for exactly one cycle. `bus_req` is never high while `busy` is low.
- R10: A request that arrives while `busy` is high is ignored: it causes no access and leaves `tf_out` unchanged.
- R11: When `req_load` and `req_read` arrive together while idle, the load is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_load | input | 1 | Start a taskfile load |
| req_read | input | 1 | Start a taskfile readback |
| field_en | input | 12 | Per-field enable mask, bit meaning as in R7 |
| lba48 | input | 1 | 48-bit addressing mode |
| flagged | input | 1 | Pass the device byte unmasked |
| drv_sel | input | 8 | Drive-select bits OR-ed into the device byte |
| tf_in | input | 104 | Taskfile image to load, slot k at bits 8k+7:8k |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| tf_out | output | 104 | Readback image, same slot layout |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_ctl | output | 1 | Access targets the device control register |
| bus_wide | output | 1 | 16-bit access |
| bus_addr | output | 3 | Taskfile register offset |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Access complete, read data valid |
| bus_rdata | input | 16 | Read data |

## Verification
The assertions assume that `bus_ack` is only raised while `bus_req` is high and lasts a single cycle, and that `bus_rdata` is valid in that acknowledge cycle. They also assume the register bus never acknowledges on its own. The bench's bus model responds only to a pending request, pulses its acknowledge for one cycle after a programmable wait of zero to two cycles, and then drops it before the next request can appear. Request pulses are one cycle wide and driven between clock edges, so every request is either accepted whole or falls entirely inside a busy window.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  localparam int SLOT_W   = 8;
  localparam int NSLOT    = 13;
  localparam int TF_W     = SLOT_W * NSLOT;
  localparam int EN_W     = 12;
  localparam int STEP_W   = 4;
  localparam int ADDR_W   = 3;
  localparam int WORD_W   = 16;
  localparam int SLOTIX_W = 4;
  localparam int HOB_BIT  = 7;

  localparam logic [STEP_W-1:0] LOAD_END = 4'd12;
  localparam logic [STEP_W-1:0] READ_END = 4'd14;
  localparam logic [7:0]        CTL_BASE = 8'h08;
  localparam logic [SLOTIX_W-1:0] DEV_SLOT = 4'd7;
  localparam logic [ADDR_W-1:0]   DEV_ADDR = 3'd6;

  typedef struct packed {
    logic                valid;
    logic                we;
    logic                wide;
    logic                ctl;
    logic                hob;
    logic [ADDR_W-1:0]   addr;
    logic [SLOTIX_W-1:0] slot;
  } step_t;

  // Mask applied to the device byte on load.
  function automatic logic [7:0] dev_mask(input logic is48, input logic flg);
    if (flg)       return 8'hFF;
    else if (is48) return 8'hE0;
    else           return 8'hEF;
  endfunction

  // Device control value: fixed base pattern, only the select bit varies.
  function automatic logic [7:0] ctl_value(input logic hob);
    logic [7:0] v;
    v = CTL_BASE;
    v[HOB_BIT] = hob;
    return v;
  endfunction

  // Decode one step of the sequence into a bus access description.
  function automatic step_t step_info(input logic rd, input logic [STEP_W-1:0] step,
                                      input logic [EN_W-1:0] en, input logic is48);
    step_t s;
    logic [2:0] k;
    s = '0;
    k = '0;
    s.we = ~rd;
    if (step == 4'd0) begin
      s.valid = en[0];
      s.wide  = 1'b1;
      s.slot  = 4'd0;
    end else if (!rd) begin
      if (step <= 4'd5) begin
        k = 3'(step - 4'd1);
        s.valid = en[4'd7 + {1'b0, k}];
        s.addr  = k + 3'd1;
        s.slot  = 4'd8 + {1'b0, k};
      end else if (step <= 4'd10) begin
        k = 3'(step - 4'd6);
        s.valid = en[4'd1 + {1'b0, k}];
        s.addr  = k + 3'd1;
        s.slot  = 4'd2 + {1'b0, k};
      end else if (step == 4'd11) begin
        s.valid = en[6];
        s.addr  = DEV_ADDR;
        s.slot  = DEV_SLOT;
      end
    end else begin
      if (step == 4'd1) begin
        s.valid = 1'b1;
        s.we    = 1'b1;
        s.ctl   = 1'b1;
      end else if (step <= 4'd6) begin
        k = 3'(step - 4'd2);
        s.valid = en[4'd1 + {1'b0, k}];
        s.addr  = k + 3'd1;
        s.slot  = 4'd2 + {1'b0, k};
      end else if (step == 4'd7) begin
        s.valid = en[6];
        s.addr  = DEV_ADDR;
        s.slot  = DEV_SLOT;
      end else if (step == 4'd8) begin
        s.valid = is48;
        s.we    = 1'b1;
        s.ctl   = 1'b1;
        s.hob   = 1'b1;
      end else if (step <= 4'd13) begin
        k = 3'(step - 4'd9);
        s.valid = is48 & en[4'd7 + {1'b0, k}];
        s.addr  = k + 3'd1;
        s.slot  = 4'd8 + {1'b0, k};
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/ata_tf_step_map.sv
module ata_tf_step_map
  import ata_tf_pkg::*;
(
  input  logic              op_rd,
  input  logic [STEP_W-1:0] step,
  input  logic [EN_W-1:0]   en,
  input  logic              is48,
  output step_t             info,
  output logic              at_end
);
  always_comb begin
    info   = step_info(op_rd, step, en, is48);
    at_end = (step == (op_rd ? READ_END : LOAD_END));
  end
endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_load,
  input  logic              start_read,
  input  logic              step_valid,
  input  logic              at_end,
  input  logic              bus_ack,
  output logic              accept,
  output logic              op_rd,
  output logic [STEP_W-1:0] step,
  output logic              in_access,
  output logic              access_done,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] { S_IDLE, S_SEEK, S_ACC } state_t;
  state_t state;

  assign accept      = (state == S_IDLE) & (start_load | start_read);
  assign in_access   = (state == S_ACC);
  assign access_done = in_access & bus_ack;
  assign busy        = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      step  <= '0;
      op_rd <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          step  <= '0;
          op_rd <= ~start_load;
          state <= S_SEEK;
        end
        S_SEEK: begin
          if (at_end) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else if (step_valid) begin
            state <= S_ACC;
          end else begin
            step <= step + 1'b1;
          end
        end
        S_ACC: if (bus_ack) begin
          step  <= step + 1'b1;
          state <= S_SEEK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_tf_result.sv
module ata_tf_result
  import ata_tf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic                wide,
  input  logic [SLOTIX_W-1:0] slot,
  input  logic [WORD_W-1:0]   rdata,
  output logic [TF_W-1:0]     image
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      image <= '0;
    end else if (capture) begin
      if (wide) image[WORD_W-1:0] <= rdata;
      else      image[{slot, 3'b000} +: SLOT_W] <= rdata[SLOT_W-1:0];
    end
  end
endmodule

// File: rtl/ata_tf_sequencer.sv
module ata_tf_sequencer
  import ata_tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_load,
  input  logic              req_read,
  input  logic [EN_W-1:0]   field_en,
  input  logic              lba48,
  input  logic              flagged,
  input  logic [7:0]        drv_sel,
  input  logic [TF_W-1:0]   tf_in,
  output logic              busy,
  output logic              done,
  output logic [TF_W-1:0]   tf_out,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_ctl,
  output logic              bus_wide,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [WORD_W-1:0] bus_rdata
);
  logic              accept, op_rd, in_access, access_done, at_end;
  logic [STEP_W-1:0] step;
  step_t             info;

  logic [EN_W-1:0] en_q;
  logic            l48_q, flg_q;
  logic [7:0]      drv_q;
  logic [TF_W-1:0] tf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      l48_q <= 1'b0;
      flg_q <= 1'b0;
      drv_q <= '0;
      tf_q  <= '0;
    end else if (accept) begin
      en_q  <= field_en;
      l48_q <= lba48;
      flg_q <= flagged;
      drv_q <= drv_sel;
      tf_q  <= tf_in;
    end
  end

  ata_tf_step_map u_map (
    .op_rd (op_rd),
    .step  (step),
    .en    (en_q),
    .is48  (l48_q),
    .info  (info),
    .at_end(at_end)
  );

  ata_tf_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_load (req_load),
    .start_read (req_read),
    .step_valid (info.valid),
    .at_end     (at_end),
    .bus_ack    (bus_ack),
    .accept     (accept),
    .op_rd      (op_rd),
    .step       (step),
    .in_access  (in_access),
    .access_done(access_done),
    .busy       (busy),
    .done       (done)
  );

  logic capture;
  assign capture = access_done & ~info.we;

  ata_tf_result u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(capture),
    .wide   (info.wide),
    .slot   (info.slot),
    .rdata  (bus_rdata),
    .image  (tf_out)
  );

  assign bus_req  = in_access;
  assign bus_we   = info.we;
  assign bus_ctl  = info.ctl;
  assign bus_wide = info.wide;
  assign bus_addr = info.addr;

  always_comb begin
    if (info.ctl)
      bus_wdata = {8'h00, ctl_value(info.hob)};
    else if (info.wide)
      bus_wdata = tf_q[WORD_W-1:0];
    else if (info.slot == DEV_SLOT)
      bus_wdata = {8'h00, (tf_q[{DEV_SLOT, 3'b000} +: SLOT_W] & dev_mask(l48_q, flg_q)) | drv_q};
    else
      bus_wdata = {8'h00, tf_q[{info.slot, 3'b000} +: SLOT_W]};
  end
endmodule

// File: rtl/ata_tf_sequencer_chk.sv
module ata_tf_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        bus_req,
  input logic        bus_ack,
  input logic        bus_we,
  input logic        bus_ctl,
  input logic        bus_wide,
  input logic [2:0]  bus_addr,
  input logic [15:0] bus_wdata
);
  // R8: a pending access holds still until acknowledged
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata)
                            && $stable(bus_we) && $stable(bus_ctl) && $stable(bus_wide));

  // R9: no bus traffic outside a transfer
  a_r9_no_bus_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  // R9: completion pulse is one cycle wide
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: busy ends exactly with the completion pulse
  a_r9_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6: control writes carry only the base pattern with the select bit
  a_r6_ctl_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ctl |-> bus_we && !bus_wide && (bus_wdata[15:8] == 8'h00)
                           && (bus_wdata[6:0] == 7'h08));

  // R4: only the data word uses a wide access
  a_r4_wide_only_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_wide |-> (bus_addr == 3'd0) && !bus_ctl);
endmodule

bind ata_tf_sequencer ata_tf_sequencer_chk u_chk (.*);

// File: tb/tb_ata_tf_sequencer.sv
`timescale 1ns/1ps
module tb_ata_tf_sequencer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, req_load, req_read, lba48, flagged;
  logic [11:0]  field_en;
  logic [7:0]   drv_sel;
  logic [103:0] tf_in, tf_out;
  logic         busy, done, bus_req, bus_we, bus_ctl, bus_wide, bus_ack;
  logic [2:0]   bus_addr;
  logic [15:0]  bus_wdata, bus_rdata;

  ata_tf_sequencer dut (.*);

  int checks = 0, errors = 0;

  // Bus model
  logic [7:0]  lo_mem [8];
  logic [7:0]  hi_mem [8];
  logic [15:0] data_word;
  logic        hob_sel;
  int          lat = 0, wcnt = 0, log_n = 0;
  logic [21:0] log_mem [64];

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; wcnt <= 0; hob_sel <= 1'b0; bus_rdata <= '0;
    end else if (bus_ack) begin
      bus_ack <= 1'b0; wcnt <= 0;
    end else if (bus_req) begin
      if (wcnt >= lat) begin
        logic [15:0] d;
        bus_ack <= 1'b1;
        if (bus_we) begin
          d = bus_wdata;
          if (bus_ctl) hob_sel <= bus_wdata[7];
        end else if (bus_wide) d = data_word;
        else d = {8'h00, hob_sel ? hi_mem[bus_addr] : lo_mem[bus_addr]};
        bus_rdata <= d;
        log_mem[log_n] <= {bus_we, bus_ctl, bus_wide, bus_addr, d};
        log_n <= log_n + 1;
      end else wcnt <= wcnt + 1;
    end
  end

  // Expected model
  logic [21:0]  exp_mem [64];
  int           exp_n;
  logic [103:0] exp_tf = '0;

  task automatic push(input bit we, input bit ctl, input bit wide, input int a, input logic [15:0] d);
    exp_mem[exp_n] = {we, ctl, wide, 3'(a), d};
    exp_n++;
  endtask

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [103:0] got, input logic [103:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", rq, what, got, expv);
    end
  endtask

  task automatic build(input bit rd, input logic [11:0] en, input bit l48, input bit flg,
                       input logic [7:0] drv, input logic [103:0] tf);
    logic [7:0] m;
    exp_n = 0;
    if (!rd) begin
      if (en[0]) push(1, 0, 1, 0, tf[15:0]);                       // R4
      for (int i = 0; i < 5; i++) if (en[7+i]) push(1, 0, 0, i+1, {8'h00, tf[(8+i)*8 +: 8]}); // R2
      for (int i = 0; i < 5; i++) if (en[1+i]) push(1, 0, 0, i+1, {8'h00, tf[(2+i)*8 +: 8]});
      m = flg ? 8'hFF : (l48 ? 8'hE0 : 8'hEF);                    // R3
      if (en[6]) push(1, 0, 0, 6, {8'h00, (tf[63:56] & m) | drv});
    end else begin
      if (en[0]) begin push(0, 0, 1, 0, data_word); exp_tf[15:0] = data_word; end
      push(1, 1, 0, 0, 16'h0008);                                   // R5
      for (int i = 0; i < 5; i++) if (en[1+i]) begin
        push(0, 0, 0, i+1, {8'h00, lo_mem[i+1]}); exp_tf[(2+i)*8 +: 8] = lo_mem[i+1];
      end
      if (en[6]) begin push(0, 0, 0, 6, {8'h00, lo_mem[6]}); exp_tf[63:56] = lo_mem[6]; end
      if (l48) begin                                                // R6
        push(1, 1, 0, 0, 16'h0088);
        for (int i = 0; i < 5; i++) if (en[7+i]) begin
          push(0, 0, 0, i+1, {8'h00, hi_mem[i+1]}); exp_tf[(8+i)*8 +: 8] = hi_mem[i+1];
        end
      end
    end
  endtask

  // One transfer; rq names the requirement under test.
  task automatic do_op(input string rq, input bit rd, input bit both, input bit poke,
                       input logic [11:0] en, input bit l48, input bit flg,
                       input logic [7:0] drv, input logic [103:0] tf);
    int base, n;
    bit seq_ok;
    build(rd & ~both, en, l48, flg, drv, tf);
    @(negedge clk);
    base = log_n;
    field_en = en; lba48 = l48; flagged = flg; drv_sel = drv; tf_in = tf;
    req_load = ~rd | both; req_read = rd | both;
    @(negedge clk);
    req_load = 0; req_read = 0;
    field_en = '1; lba48 = ~l48; flagged = ~flg; drv_sel = ~drv; tf_in = ~tf;
    check(busy === 1'b1, "R9", "busy after accept", {103'b0, busy}, 104'd1);
    n = 0;
    while (done !== 1'b1 && n < 500) begin
      if (poke && n == 1) begin req_read = 1; req_load = 1; end   // R10
      if (poke && n == 2) begin req_read = 0; req_load = 0; end
      @(negedge clk); n++;
    end
    req_read = 0; req_load = 0;
    check(n < 500, rq, "completion before watchdog", 104'(n), 104'd500);
    check(busy === 1'b0, "R9", "busy low with done", {103'b0, busy}, 104'd0);
    @(negedge clk);
    check(done === 1'b0, "R9", "done one cycle", {103'b0, done}, 104'd0);
    seq_ok = (log_n - base) == exp_n;
    check(seq_ok, rq, "access count", 104'(log_n - base), 104'(exp_n));
    for (int i = 0; i < exp_n && seq_ok; i++) begin
      if (log_mem[base+i] !== exp_mem[i]) begin
        seq_ok = 0;
        check(0, rq, $sformatf("access %0d", i), 104'(log_mem[base+i]), 104'(exp_mem[i]));
      end
    end
    if (seq_ok) check(1, rq, "sequence", 0, 0);
    check(tf_out === exp_tf, rq, "result image", tf_out, exp_tf);
    if (poke) begin
      n = log_n;
      repeat (10) @(negedge clk);
      check(busy === 1'b0 && log_n == n, "R10", "no second transfer", 104'(log_n), 104'(n));
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog expired actual %0d expected below 100000", wd);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  localparam logic [103:0] TFA = 104'hC3_B2_A1_90_8F_5D_4C_3B_2A_19_08_F7_E6;
  localparam logic [103:0] TFB = 104'h11_22_33_44_55_FF_66_77_88_99_AA_BB_CC;

  initial begin
    rst_n = 0; req_load = 0; req_read = 0; field_en = 0; lba48 = 0; flagged = 0;
    drv_sel = 0; tf_in = 0;
    for (int i = 0; i < 8; i++) begin
      lo_mem[i] = 8'(8'h30 + i * 7);
      hi_mem[i] = 8'(8'hA0 + i * 5);
    end
    data_word = 16'hBEEF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy === 0 && done === 0 && bus_req === 0, "R1", "control outputs after reset",
          {101'b0, busy, done, bus_req}, 0);
    check(tf_out === '0, "R1", "result image after reset", tf_out, 0);

    lat = 0;
    do_op("R2", 0, 0, 0, 12'hFFF, 0, 0, 8'h10, TFA);        // full load, 28-bit mask
    lat = 2;
    do_op("R3", 0, 0, 0, 12'hFFF, 1, 0, 8'h10, TFB);        // 48-bit mask
    lat = 1;
    do_op("R3", 0, 0, 0, 12'h040, 1, 1, 8'h00, TFB);        // flagged passes all bits
    do_op("R7", 0, 0, 0, 12'h52A, 0, 0, 8'h00, TFA);        // partial mask load
    do_op("R4", 0, 0, 0, 12'h001, 0, 0, 8'h00, TFA);        // data word only
    lat = 0;
    do_op("R5", 1, 0, 0, 12'h07F, 0, 0, 8'h00, TFA);        // 28-bit readback
    lat = 2;
    do_op("R6", 1, 0, 0, 12'hFFF, 1, 0, 8'h00, TFA);        // 48-bit readback
    hi_mem[3] = 8'h5A; lo_mem[2] = 8'hC7; data_word = 16'h1234;
    lat = 1;
    do_op("R7", 1, 0, 0, 12'h8C5, 1, 0, 8'h00, TFB);        // partial readback
    do_op("R6", 1, 0, 0, 12'hF80, 0, 0, 8'h00, TFB);        // hob enables without 48-bit mode
    data_word = 16'h0F0F;
    do_op("R4", 1, 0, 0, 12'h001, 0, 0, 8'h00, TFB);        // data word readback
    do_op("R10", 0, 0, 1, 12'hFFF, 1, 0, 8'h10, TFA);       // request while busy
    lo_mem[4] = 8'h99;
    do_op("R11", 1, 1, 0, 12'h07F, 0, 0, 8'h00, TFB);       // simultaneous: load wins

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule